// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block carries interrupts between the cores of a small cluster. Every core owns a command port (a valid strobe, an opcode and a core-number argument) and gets back a registered readback word. With these commands a core can signal another core, ask whether a signal it sent is still unanswered, ask which cores are signalling it, and acknowledge one sender at a time. Each core has one interrupt output line.

The pending state is held per target and sender in an N x N bit matrix. Signals from several senders to the same target share that target's single line, and the target sees them as a sender bitmask. One command is executed per cycle. When several cores present commands at once, a fixed-priority arbiter serves the lowest-numbered core first and holds `cmd_ready` low for the others. A small two-state machine for each target drives its line. The states are LINE_QUIET and LINE_RAISED. The transition QUIET->RAISED occurs when the target's next pending row becomes nonzero. The transition RAISED->QUIET occurs when that row becomes all zero.

Opcodes: 1 = raise, 2 = peek (pending status), 3 = who (source mask), 4 = acknowledge. All other codes are unknown.

Top module: `ipi_cluster_ctrl`

## Requirements
- R1: After reset all `irq` lines, all `rb_valid` bits and every readback word are zero, and no sender is pending at any target.
- R2: When core s has a raise command (opcode 1) with argument t < N_CORES accepted, pair (t, s) becomes pending and `irq[t]` is high in the cycle after acceptance.
- R3: A peek command (opcode 2) with argument t from core s returns readback 1 if pair (t, s) is pending, and 0 otherwise.
- R4: A who command (opcode 3) from core t returns a readback word whose bit s is 1 exactly when pair (t, s) is pending. Several senders to t share the single line `irq[t]`, so the mask can have several bits set.
- R5: An acknowledge command (opcode 4) with argument s from core t clears only pair (t, s). Every other pair keeps its state.
- R6: `irq[t]` stays high while any sender is pending toward t. It goes low in the cycle after the last pending sender is acknowledged.
- R7: A raise on a pair that is already pending changes no state. A later who command sees the same mask, and a single acknowledge clears the pair.
- R8: `rb_valid[c]` pulses for exactly one cycle, one cycle after core c's command is accepted. The readback word of core c then holds until c's next accepted command. Raise and acknowledge commands return 0.
- R9: `cmd_ready[c]` is low exactly when a lower-numbered core asserts `cmd_valid`. Only the lowest-numbered valid core is accepted in a cycle.
- R10: An unknown opcode (0 or 5 to 31) changes no pending state and returns readback 0.
- R11: An argument >= N_CORES makes raise and acknowledge have no effect, and makes peek return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | N_CORES | Command strobe, one bit per core |
| cmd_op | input | N_CORES*5 | Opcode, field c*5 +: 5 for core c |
| cmd_arg | input | N_CORES*5 | Core-number argument, field c*5 +: 5 |
| cmd_ready | output | N_CORES | Command accepted this cycle if valid |
| rb_valid | output | N_CORES | One-cycle pulse, readback updated |
| rb_data | output | N_CORES*32 | Readback word, field c*32 +: 32 |
| irq | output | N_CORES | Interrupt line to each core |

## Verification
The bench raises every sender-target pair and checks each line, each source mask and each peek result, which exposes a transposed matrix index (a design that indexed by sender in place of target would light the wrong line). It then acknowledges senders one at a time and checks that each line drops only after its last sender clears. A design that cleared a whole row, or dropped the line early, fails at the first partial acknowledge. A second raise on a pending pair, every unknown opcode and every argument beyond the last core are applied, and the bench checks that masks and lines stay unchanged; a design that toggled state or decoded the low argument bits would alter them. Finally all four cores issue commands together, and the bench checks the ready pattern and the single served core in each cycle; a design that served the highest-numbered core first, or served two cores in one cycle, would show a different pattern.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int OPW = 5;

    localparam logic [OPW-1:0] OPC_RAISE = 5'd1;
    localparam logic [OPW-1:0] OPC_PEEK  = 5'd2;
    localparam logic [OPW-1:0] OPC_WHO   = 5'd3;
    localparam logic [OPW-1:0] OPC_ACK   = 5'd4;

    typedef enum logic [2:0] {
        K_NONE,
        K_RAISE,
        K_PEEK,
        K_WHO,
        K_ACK,
        K_BAD
    } cmd_kind_e;

    typedef enum logic {
        LINE_QUIET,
        LINE_RAISED
    } line_state_e;

    function automatic cmd_kind_e decode_op(input logic go, input logic [OPW-1:0] op);
        cmd_kind_e k;
        if (!go) begin
            k = K_NONE;
        end else begin
            unique case (op)
                OPC_RAISE: k = K_RAISE;
                OPC_PEEK:  k = K_PEEK;
                OPC_WHO:   k = K_WHO;
                OPC_ACK:   k = K_ACK;
                default:   k = K_BAD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/ipi_prio_arb.sv
module ipi_prio_arb #(
    parameter int N    = 4,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    output logic [N-1:0]    ready,
    output logic [N-1:0]    grant,
    output logic [IDXW-1:0] grant_idx,
    output logic            any
);

    always_comb begin
        logic blocked;
        blocked   = 1'b0;
        grant_idx = '0;
        for (int c = 0; c < N; c++) begin
            ready[c] = ~blocked;
            grant[c] = req[c] & ~blocked;
            if (grant[c]) begin
                grant_idx = IDXW'(c);
            end
            blocked = blocked | req[c];
        end
        any = blocked;
    end

endmodule

// File: rtl/ipi_pend_matrix.sv
module ipi_pend_matrix
    import ipi_pkg::*;
#(
    parameter int N     = 4,
    parameter int ARG_W = 5,
    parameter int RB_W  = 32,
    parameter int IDXW  = (N > 1) ? $clog2(N) : 1,
    parameter int CELLS = N * N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_kind_e        kind,
    input  logic [IDXW-1:0]  src,
    input  logic [ARG_W-1:0] arg,
    output logic [CELLS-1:0] pend_q,
    output logic [CELLS-1:0] pend_d,
    output logic [RB_W-1:0]  rb_value
);

    logic arg_ok;
    int   src_i;
    int   arg_i;

    assign src_i  = int'(src);
    assign arg_i  = int'(arg);
    assign arg_ok = (arg_i < N);

    // next state of the matrix: row t holds the senders pending toward t
    always_comb begin
        pend_d = pend_q;
        unique case (kind)
            K_RAISE: if (arg_ok) pend_d[arg_i*N + src_i] = 1'b1;
            K_ACK:   if (arg_ok) pend_d[src_i*N + arg_i] = 1'b0;
            default: ;
        endcase
    end

    // readback word computed from the state before this command
    always_comb begin
        rb_value = '0;
        unique case (kind)
            K_PEEK: if (arg_ok) rb_value[0] = pend_q[arg_i*N + src_i];
            K_WHO:  rb_value[N-1:0] = pend_q[src_i*N +: N];
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/ipi_line_fsm.sv
module ipi_line_fsm
    import ipi_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] row_next,
    output logic         irq
);

    line_state_e state_q;
    line_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (|row_next)  state_d = LINE_RAISED;
            LINE_RAISED: if (~|row_next) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LINE_RAISED: irq = 1'b1;
            default:     irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/ipi_cluster_ctrl.sv
module ipi_cluster_ctrl
    import ipi_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int ARG_W   = 5,
    parameter int RB_W    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CORES-1:0]       cmd_valid,
    input  logic [N_CORES*OPW-1:0]   cmd_op,
    input  logic [N_CORES*ARG_W-1:0] cmd_arg,
    output logic [N_CORES-1:0]       cmd_ready,
    output logic [N_CORES-1:0]       rb_valid,
    output logic [N_CORES*RB_W-1:0]  rb_data,
    output logic [N_CORES-1:0]       irq
);

    localparam int IDXW  = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam int CELLS = N_CORES * N_CORES;

    logic [N_CORES-1:0] grant;
    logic [IDXW-1:0]    grant_idx;
    logic               any_go;
    logic [OPW-1:0]     sel_op;
    logic [ARG_W-1:0]   sel_arg;
    cmd_kind_e          kind;
    logic [CELLS-1:0]   pend_q;
    logic [CELLS-1:0]   pend_d;
    logic [RB_W-1:0]    rb_value;

    ipi_prio_arb #(.N(N_CORES), .IDXW(IDXW)) u_arb (
        .req       (cmd_valid),
        .ready     (cmd_ready),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (any_go)
    );

    always_comb begin
        sel_op  = '0;
        sel_arg = '0;
        for (int c = 0; c < N_CORES; c++) begin
            if (grant[c]) begin
                sel_op  = cmd_op[c*OPW +: OPW];
                sel_arg = cmd_arg[c*ARG_W +: ARG_W];
            end
        end
    end

    assign kind = decode_op(any_go, sel_op);

    ipi_pend_matrix #(
        .N(N_CORES), .ARG_W(ARG_W), .RB_W(RB_W), .IDXW(IDXW), .CELLS(CELLS)
    ) u_mat (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .src      (grant_idx),
        .arg      (sel_arg),
        .pend_q   (pend_q),
        .pend_d   (pend_d),
        .rb_value (rb_value)
    );

    for (genvar t = 0; t < N_CORES; t++) begin : g_line
        ipi_line_fsm #(.N(N_CORES)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .row_next (pend_d[t*N_CORES +: N_CORES]),
            .irq      (irq[t])
        );
    end

    for (genvar c = 0; c < N_CORES; c++) begin : g_rb
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rb_valid[c]              <= 1'b0;
                rb_data[c*RB_W +: RB_W]  <= '0;
            end else begin
                rb_valid[c] <= grant[c];
                if (grant[c]) begin
                    rb_data[c*RB_W +: RB_W] <= rb_value;
                end
            end
        end
    end

endmodule

// File: rtl/ipi_cluster_chk.sv
module ipi_cluster_chk
    import ipi_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int ARG_W   = 5,
    parameter int RB_W    = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_CORES-1:0]       cmd_valid,
    input logic [N_CORES*OPW-1:0]   cmd_op,
    input logic [N_CORES*ARG_W-1:0] cmd_arg,
    input logic [N_CORES-1:0]       cmd_ready,
    input logic [N_CORES-1:0]       rb_valid,
    input logic [N_CORES*RB_W-1:0]  rb_data,
    input logic [N_CORES-1:0]       irq
);

    logic [N_CORES-1:0] acc;
    assign acc = cmd_valid & cmd_ready;

    // R9: at most one command accepted per cycle, core 0 never stalled
    a_r9_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc));
    a_r9_core0_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready[0]);

    // R6: lines move only when a command is accepted
    a_r6_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == '0) |=> $stable(irq));

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        // R8: readback pulse follows acceptance by one cycle
        a_r8_rb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            acc[c] |=> rb_valid[c]);
        a_r8_rb_only_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
            !acc[c] |=> !rb_valid[c]);

        // R10: unknown opcodes read back zero
        a_r10_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (acc[c] && (cmd_op[c*OPW +: OPW] == 5'd0 || cmd_op[c*OPW +: OPW] > 5'd4))
            |=> (rb_data[c*RB_W +: RB_W] == '0));

        if (c > 0) begin : g_stall
            // R9: a lower valid core stalls this one
            a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_valid[c-1] |-> !cmd_ready[c]);
        end

        for (genvar t = 0; t < N_CORES; t++) begin : g_tgt
            // R2: an accepted raise lights the target's line next cycle
            a_r2_raise_lights: assert property (@(posedge clk) disable iff (!rst_n)
                (acc[c] && cmd_op[c*OPW +: OPW] == OPC_RAISE &&
                 int'(cmd_arg[c*ARG_W +: ARG_W]) == t) |=> irq[t]);
        end
    end

endmodule

bind ipi_cluster_ctrl ipi_cluster_chk #(
    .N_CORES(N_CORES), .ARG_W(ARG_W), .RB_W(RB_W)
) u_chk (.*);

// File: tb/sim_ipi_cluster_ctrl.sv
module sim_ipi_cluster_ctrl;

    localparam int N  = 4;
    localparam int OW = 5;
    localparam int AW = 5;
    localparam int RW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    cmd_valid = '0;
    logic [N*OW-1:0] cmd_op = '0;
    logic [N*AW-1:0] cmd_arg = '0;
    logic [N-1:0]    cmd_ready;
    logic [N-1:0]    rb_valid;
    logic [N*RW-1:0] rb_data;
    logic [N-1:0]    irq;

    int nvec = 0;
    int nbad = 0;
    logic [N-1:0] model [N];   // model[t][s]: s pending toward t

    always #10 clk = ~clk;

    ipi_cluster_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .rb_valid(rb_valid),
        .rb_data(rb_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_irq();
        logic [N-1:0] v;
        for (int t = 0; t < N; t++) v[t] = |model[t];
        return v;
    endfunction

    // issue one command from core c, check readback and lines
    task automatic issue(input int c, input int op, input int arg,
                         input logic [31:0] exp_rb, input string req);
        @(negedge clk);
        cmd_valid[c]          = 1'b1;
        cmd_op[c*OW +: OW]    = OW'(op);
        cmd_arg[c*AW +: AW]   = AW'(arg);
        #1 chk("R9", 32'(cmd_ready[c]), 32'd1);
        @(negedge clk);
        cmd_valid[c] = 1'b0;
        if (op == 1 && arg < N) model[arg][c] = 1'b1;
        if (op == 4 && arg < N) model[c][arg] = 1'b0;
        chk("R8", 32'(rb_valid), 32'(1 << c));
        chk(req, rb_data[c*RW +: RW], exp_rb);
        chk("R6", 32'(irq), 32'(exp_irq()));
    endtask

    task automatic check_who_all(input string req);
        for (int t = 0; t < N; t++) issue(t, 3, 0, 32'(model[t]), req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        for (int t = 0; t < N; t++) model[t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", 32'(irq), 0);
        chk("R1", 32'(rb_valid), 0);
        chk("R1", rb_data[31:0] | rb_data[63:32] | rb_data[95:64] | rb_data[127:96], 0);
        check_who_all("R1");

        // R2, R3: raise every pair, peek before and after
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                issue(s, 2, t, 32'(model[t][s]), "R3");
                issue(s, 1, t, 0, "R2");
                chk("R2", 32'(irq[t]), 1);
                issue(s, 2, t, 1, "R3");
            end
        end
        // R4: coalesced masks
        check_who_all("R4");
        // R7: second raise on pending pair
        issue(2, 1, 1, 0, "R7");
        check_who_all("R7");

        // R10: unknown opcodes with every argument value pattern
        for (int op = 0; op < 32; op++) begin
            if (op >= 1 && op <= 4) continue;
            issue(op % N, op, (op * 7) % 32, 0, "R10");
        end
        check_who_all("R10");

        // R5, R6: acknowledge one sender at a time
        for (int t = 0; t < N; t++) begin
            for (int s = 0; s < N; s++) begin
                issue(t, 4, s, 0, "R5");
                chk("R6", 32'(irq[t]), 32'(s != N - 1));
                issue(t, 3, 0, 32'(model[t]), "R5");
            end
        end
        check_who_all("R5");

        // R11: out-of-range arguments
        issue(1, 1, 2, 0, "R2");
        for (int a = N; a < 32; a++) begin
            issue(0, 1, a, 0, "R11");
            issue(2, 2, a, 0, "R11");
            issue(1, 4, a, 0, "R11");
        end
        check_who_all("R11");
        issue(2, 4, 1, 0, "R5");
        chk("R7", 32'(irq), 0);

        // R9: all cores at once, each raising the next core
        @(negedge clk);
        cmd_valid = '1;
        for (int c = 0; c < N; c++) begin
            cmd_op[c*OW +: OW]  = OW'(1);
            cmd_arg[c*AW +: AW] = AW'((c + 1) % N);
        end
        for (int round = 0; round < N; round++) begin
            logic [N-1:0] er;
            int served;
            served = -1;
            for (int c = 0; c < N; c++) begin
                er[c] = ((cmd_valid & N'((1 << c) - 1)) == '0);
                if (served < 0 && cmd_valid[c]) served = c;
            end
            #1 chk("R9", 32'(cmd_ready), 32'(er));
            @(negedge clk);
            model[(served + 1) % N][served] = 1'b1;
            chk("R9", 32'(rb_valid), 32'(1 << served));
            chk("R2", 32'(irq), 32'(exp_irq()));
            cmd_valid[served] = 1'b0;
        end
        check_who_all("R9");
        // R8: readback word holds when no new command
        @(negedge clk);
        chk("R8", 32'(rb_valid), 0);
        chk("R8", rb_data[3*RW +: RW], 32'(model[3]));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule